// File: doc/BRIEF.md
# Circular Call/Return Address Stack

This block keeps the return addresses of a small processor. Each push stores a 13-bit address on top of an eight-entry stack. A push happens when a subroutine call executes or when an interrupt vectors. Each pop drops the top entry. A pop happens on any of the three return-type instructions: plain return, return carrying a literal, and return from interrupt. The current top entry is always visible on a combinational output, so the fetch logic can load it into the program counter in the same cycle as the pop.

The storage is a private array. It sits outside both program memory and data memory. The pointer that selects the top slot has no read or write path. The stack is a ring and has no overflow or underflow flags. A ninth push without a pop overwrites the oldest entry. A pop on an empty stack wraps the pointer backward and exposes whatever that slot still holds. Reset moves the pointer back to slot zero but leaves the stored addresses as they were.

Top module: `ring_stack_top`

## Requirements
- R1: The stack has 8 slots of 13 bits. A push writes `pushAddr` into the slot at the pointer. From the next cycle on, `topAddr` shows that address.
- R2: A pop without a push moves the pointer back by one slot. From the next cycle on, `topAddr` shows the entry below the one removed, so addresses come back in last-in, first-out order.
- R3: The pointer wraps modulo 8 when it moves forward. After pushes v0 to v8 with no pops, v8 has replaced v0 in slot 0. Eight pops after that then show v7, v6 and so on down to v1, and finally v8 again.
- R4: The pointer also wraps modulo 8 when it moves backward. A pop right after reset moves the pointer from 0 to 7, and `topAddr` then shows the contents of slot 6.
- R5: Reset sets the pointer to 0 and keeps all stored entries. Just after reset, `topAddr` shows the contents of slot 7.
- R6: If a push and a pop are asserted in the same cycle, the push is performed and the pop is ignored. The pointer moves forward by one, and `topAddr` shows the pushed address.
- R7: In a cycle with neither a push nor a pop, the pointer and the stored entries keep their values, so `topAddr` does not change.
- R8: The block has no overflow or underflow indication. Pushes and pops after any number of wraps keep the same last-in, first-out relation with the slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset of the pointer only |
| pushEn | input | 1 | Push strobe (a call, or an interrupt vectoring) |
| pushAddr | input | 13 | Address stored by a push |
| popEn | input | 1 | Pop strobe (any return-type instruction) |
| topAddr | output | 13 | Entry at the top of the stack |

## Verification
The assertions check the single-cycle rules on every clock:
- the pointer moves by exactly one slot, with wrap, on a push or a pop;
- a pushed address appears on top in the next cycle, even when a pop is asserted at the same time;
- an idle cycle leaves the top unchanged;
- a pop that follows a push brings back the earlier top.

Only the bench's scenarios can show the behaviours that span many cycles:
- the ninth push overwriting the oldest slot;
- the pops that then walk back through the wrapped ring;
- an underflow pop exposing a stale slot;
- stored contents surviving a reset.

// File: rtl/ring_stack_pkg.sv
package ring_stack_pkg;
  localparam int unsigned SLOTS   = 8;
  localparam int unsigned ENTRY_W = 13;
  localparam int unsigned IDX_W   = $clog2(SLOTS);

  // Strobes and indices handed from the pointer control to the storage
  typedef struct packed {
    logic             wrStrobe;
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;
  } ringCmd_t;
endpackage

// File: rtl/ring_stack_ctrl.sv
module ring_stack_ctrl
  import ring_stack_pkg::*;
#(
  parameter int unsigned DEPTH = SLOTS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic             popEn,
  output ringCmd_t         cmd,
  output logic [IDX_W-1:0] ptrQ
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptrUp;
  logic [IDX_W-1:0] ptrDn;

  // wrap both ways, valid for any depth
  assign ptrUp = (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
  assign ptrDn = (ptrQ == '0) ? LAST : ptrQ - 1'b1;

  // push wins over pop when both strobes are seen
  always_ff @(posedge clk) begin
    if (!rstN)       ptrQ <= '0;
    else if (pushEn) ptrQ <= ptrUp;
    else if (popEn)  ptrQ <= ptrDn;
  end

  always_comb begin
    cmd.wrStrobe = pushEn && rstN;
    cmd.wrIdx    = ptrQ;
    cmd.rdIdx    = ptrDn;
  end
endmodule

// File: rtl/ring_stack_store.sv
module ring_stack_store
  import ring_stack_pkg::*;
#(
  parameter int unsigned DEPTH = SLOTS,
  parameter int unsigned WIDTH = ENTRY_W
) (
  input  logic             clk,
  input  ringCmd_t         cmd,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] slotQ [DEPTH];

  // contents have no reset by design
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (cmd.wrStrobe && cmd.wrIdx == IDX_W'(g)) slotQ[g] <= wrData;
    end
  end

  assign rdData = slotQ[cmd.rdIdx];
endmodule

// File: rtl/ring_stack_top.sv
module ring_stack_top
  import ring_stack_pkg::*;
#(
  parameter int unsigned DEPTH = SLOTS,
  parameter int unsigned WIDTH = ENTRY_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushAddr,
  input  logic             popEn,
  output logic [WIDTH-1:0] topAddr
);
  ringCmd_t         cmd;
  logic [IDX_W-1:0] stkPtr;

  ring_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
    .cmd(cmd), .ptrQ(stkPtr)
  );

  ring_stack_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .cmd(cmd), .wrData(pushAddr), .rdData(topAddr)
  );
endmodule

// File: rtl/ring_stack_chk.sv
module ring_stack_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned WIDTH = 13,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rstN,
  input logic             pushEn,
  input logic             popEn,
  input logic [WIDTH-1:0] pushAddr,
  input logic [WIDTH-1:0] topAddr,
  input logic [IDX_W-1:0] ptrQ
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  // R1
  push_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |=> topAddr == $past(pushAddr));

  // R3
  push_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    pushEn |=> ptrQ == (($past(ptrQ) == LAST) ? '0 : $past(ptrQ) + 1'b1));

  // R4
  pop_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn) |=> ptrQ == (($past(ptrQ) == '0) ? LAST : $past(ptrQ) - 1'b1));

  // R2
  pop_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && $past(pushEn) && $past(rstN)) |=> topAddr == $past(topAddr, 2));

  // R6
  push_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && popEn) |=> (topAddr == $past(pushAddr)) && (ptrQ != $past(ptrQ)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pushEn && !popEn) |=> $stable(topAddr) && $stable(ptrQ));
endmodule

bind ring_stack_top ring_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .pushEn(pushEn), .popEn(popEn),
  .pushAddr(pushAddr), .topAddr(topAddr), .ptrQ(stkPtr)
);

// File: tb/sim_ring_stack_top.sv
`timescale 1ns/1ps
module sim_ring_stack_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushEn = 1'b0;
  logic        popEn = 1'b0;
  logic [12:0] pushAddr = '0;
  logic [12:0] topAddr;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  // reference model built from the requirements
  logic [12:0] mdlMem [8];
  bit          mdlValid [8];
  int          mdlPtr = 0;

  always #2 clk = ~clk;

  ring_stack_top u0 (
    .clk(clk), .rstN(rstN), .pushEn(pushEn), .pushAddr(pushAddr),
    .popEn(popEn), .topAddr(topAddr)
  );

  function automatic int expIdx();
    return (mdlPtr + 7) % 8;
  endfunction

  task automatic chk(input string req, input logic [12:0] exp);
    checkCnt++;
    if (topAddr !== exp) begin
      failCnt++;
      $display("FAIL %s: topAddr=%h expected=%h", req, topAddr, exp);
    end
  endtask

  task automatic chkModel(input string req);
    if (mdlValid[expIdx()]) chk(req, mdlMem[expIdx()]);
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic step(input bit p, input bit q, input logic [12:0] a);
    pushEn = p; popEn = q; pushAddr = a;
    @(posedge clk);
    if (p) begin
      mdlMem[mdlPtr] = a; mdlValid[mdlPtr] = 1'b1; mdlPtr = (mdlPtr + 1) % 8;
    end else if (q) begin
      mdlPtr = (mdlPtr + 7) % 8;
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; pushEn = 1'b0; popEn = 1'b0;
    repeat (2) @(posedge clk);
    mdlPtr = 0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdlValid[i] = 1'b0;
    void'($urandom(32'd4711));
    @(negedge clk);
    doReset();

    // R1 / R3: nine pushes, the ninth lands in slot 0
    for (int i = 0; i < 9; i++) begin
      step(1'b1, 1'b0, 13'h100 + 13'(i));
      chk("R1", 13'h100 + 13'(i));
    end
    // R2 / R3: eight pops walk v7..v1 then wrap to v8
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b1, '0);
      if (i < 7) chk("R2", 13'h107 - 13'(i));
      else       chk("R3", 13'h108);
    end

    // R5: pointer to 0, contents kept, top shows slot 7
    doReset();
    chk("R5", 13'h107);

    // R4: pop on an empty stack shows slot 6
    step(1'b0, 1'b1, '0);
    chk("R4", 13'h106);

    // R6: push and pop together -> push performed
    step(1'b1, 1'b1, 13'h0AA);
    chk("R6", 13'h0AA);
    step(1'b0, 1'b1, '0);
    chk("R6", 13'h106);

    // R7: idle cycles leave the top alone
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 13'h1FFF);
      chk("R7", 13'h106);
    end

    // R8: random traffic across many wraps
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      bit p = (r < 45) || (r >= 95);
      bit q = (r >= 45 && r < 85) || (r >= 95);
      step(p, q, 13'($urandom));
      chkModel("R8");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule